// File: doc/BRIEF.md
# Indirect Configuration Access Semaphore

This block is the register side of a bridge that runs configuration cycles for masters indirectly. It has two lanes. Lane 0 carries downstream traffic and lane 1 carries upstream traffic. Each lane owns an address register, a data register, an enable bit and a self-response enable bit. Each lane also has a lock bit that software takes by reading it. A read of the lock that returns 0 sets the lock to 1, provided the lane is enabled. While the lock is held, any later read returns 1 and changes nothing. The lock drops by itself when the far bus reports that the configuration transaction has completed.

An access to a lane's data register while the lane is enabled sends a one-cycle request to the far-side bus engine. The request carries the lane's address and data registers and a write/read flag. Each lane keeps at most one request outstanding. An access that arrives while a request is pending is stalled: `busy` is raised and the access has no effect. A completion that ends a read request loads the returned word into the data register. A control word at address 0x00 holds the enables and a read-only mirror of both lock bits. Reading the control word never takes a lock.

Top module: `cfgsema_top`

## Requirements
- R1: After reset all lock bits, enables, self-response enables and requests are 0. `rdata` is 0 and a control read returns 0x0000.
- R2: A read of a lane's lock register (lane 0 at 0x10, lane 1 at 0x18, lock in bit 0) returns 0 when the lock is free and the lane is enabled. The lock is held from the next cycle on.
- R3: While a lock is held, reads of its lock register return 1 and leave it held.
- R4: A `lane_done` pulse for a lane releases that lane's lock.
- R5: Control word bits 8 (lane 0) and 9 (lane 1) mirror the lock bits. Reading the control word never takes a lock.
- R6: With a lane's enable clear, a lock read does not take the lock. An access to that lane's data register (0x14 or 0x1C) issues no request, a write to it is ignored, and a read of it returns 0.
- R7: With a lane's enable set, an access to its data register raises `lane_req` for exactly the cycle after the strobe. `lane_req_wr` is 1 for a write and 0 for a read. The request presents the lane's address register (0x12 or 0x1A) and data register. The completion of a read loads `lane_done_data` into the data register.
- R8: A data-register access while that lane's request is still pending raises `busy` in the strobe cycle. It issues no request and does not change the data register.
- R9: When a lock read and a completion for the same lane fall in the same cycle, the completion is applied first: the read returns 0 and takes the lock.
- R10: Control bits 2L and 2L+1 are lane L's enable and self-response enable, and `lane_self_en` follows them. All other bits of every register read as 0, and writes to them are ignored.
- R11: Lock, request and completion activity on one lane leaves the other lane's lock unchanged.
- R12: `rdata` shows the addressed word from the clock edge after `rd_stb` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle register read strobe |
| wr_stb | input | 1 | One-cycle register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| busy | output | 1 | Data-register access stalled by a pending request |
| lane_req | output | LANES | One-cycle configuration request per lane |
| lane_req_wr | output | LANES | Request is a write (1) or a read (0) |
| lane_cfg_addr | output | LANES*DW | Per-lane address register |
| lane_cfg_data | output | LANES*DW | Per-lane data register |
| lane_self_en | output | LANES | Per-lane self-response enable |
| lane_done | input | LANES | Far-bus completion pulse per lane |
| lane_done_data | input | LANES*DW | Read data returned with a completion |

## Verification
A lock stuck at 1 shows on the very next lock read as a returned 1 where 0 is expected, and it also shows in the control mirror bits. A lock stuck at 0 shows the same way, with a 0 where 1 is expected. A wrong pending flag shows in the strobe cycle of the following data access, either as a spurious `busy` or as a second `lane_req` one cycle later. A data register that lost or overwrote a value shows on the next read of that register, or on the next `lane_cfg_data` presented with a request.

// File: rtl/cfgsema_pkg.sv
package cfgsema_pkg;
  localparam int SLOT_LOCK = 0;
  localparam int SLOT_ADDR = 1;
  localparam int SLOT_DATA = 2;
  localparam logic [15:0] A_CTRL = 16'h0000;

  // byte address of a lane register: lanes start at 0x10, 8 bytes apart
  function automatic logic [15:0] reg_addr(input int lane, input int slot);
    return 16'(16 + 8 * lane + 2 * slot);
  endfunction

  function automatic int en_bit(input int lane);
    return 2 * lane;
  endfunction

  function automatic int self_bit(input int lane);
    return 2 * lane + 1;
  endfunction

  function automatic int lock_bit(input int lane);
    return 8 + lane;
  endfunction
endpackage

// File: rtl/cfgsema_lane.sv
module cfgsema_lane #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic          addr_wr,
  input  logic          ctrl_wr,
  input  logic          ctrl_en_d,
  input  logic          ctrl_self_d,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  input  logic [DW-1:0] done_data,
  output logic          lock_eff,
  output logic          lock_q,
  output logic          en_q,
  output logic          self_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] data_view,
  output logic          req_q,
  output logic          req_wr_q,
  output logic          stall,
  output logic          claim_ev,
  output logic          release_ev
);
  logic pend_q, pend_wr_q, pend_eff, data_acc, issue;

  // completion is applied before any access in the same cycle
  assign release_ev = done;
  assign lock_eff   = lock_q & ~done;
  assign claim_ev   = lock_rd & en_q & ~lock_eff;
  assign pend_eff   = pend_q & ~done;
  assign data_acc   = (data_rd | data_wr) & en_q;
  assign stall      = data_acc & pend_eff;
  assign issue      = data_acc & ~pend_eff;
  assign data_view  = en_q ? data_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
      req_q     <= 1'b0;
      req_wr_q  <= 1'b0;
      en_q      <= 1'b0;
      self_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      lock_q   <= claim_ev | lock_eff;
      pend_q   <= issue | pend_eff;
      req_q    <= issue;
      req_wr_q <= issue & data_wr;
      if (issue) pend_wr_q <= data_wr;
      if (ctrl_wr) begin
        en_q   <= ctrl_en_d;
        self_q <= ctrl_self_d;
      end
      if (addr_wr) addr_q <= wdata;
      if (issue && data_wr)                 data_q <= wdata;
      else if (done && pend_q && !pend_wr_q) data_q <= done_data;
    end
  end
endmodule

// File: rtl/cfgsema_rdmux.sv
module cfgsema_rdmux
  import cfgsema_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic [15:0]         addr16,
  input  logic [LANES-1:0]    lock_eff,
  input  logic [LANES-1:0]    en,
  input  logic [LANES-1:0]    self_en,
  input  logic [LANES*DW-1:0] addr_regs,
  input  logic [LANES*DW-1:0] data_views,
  output logic [DW-1:0]       word
);
  always_comb begin
    word = '0;
    if (addr16 == A_CTRL) begin
      for (int l = 0; l < LANES; l++) begin
        word[en_bit(l)]   = en[l];
        word[self_bit(l)] = self_en[l];
        word[lock_bit(l)] = lock_eff[l];
      end
    end
    for (int l = 0; l < LANES; l++) begin
      if (addr16 == reg_addr(l, SLOT_LOCK)) word[0] = lock_eff[l];
      if (addr16 == reg_addr(l, SLOT_ADDR)) word = addr_regs[l*DW +: DW];
      if (addr16 == reg_addr(l, SLOT_DATA)) word = data_views[l*DW +: DW];
    end
  end
endmodule

// File: rtl/cfgsema_top.sv
module cfgsema_top
  import cfgsema_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 16,
  parameter int LANES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                busy,
  output logic [LANES-1:0]    lane_req,
  output logic [LANES-1:0]    lane_req_wr,
  output logic [LANES*DW-1:0] lane_cfg_addr,
  output logic [LANES*DW-1:0] lane_cfg_data,
  output logic [LANES-1:0]    lane_self_en,
  input  logic [LANES-1:0]    lane_done,
  input  logic [LANES*DW-1:0] lane_done_data
);
  logic [15:0]         addr16;
  logic [LANES-1:0]    lock_eff_vec, lock_q_vec, en_vec, stall_vec;
  logic [LANES-1:0]    claim_vec, release_vec;
  logic [LANES*DW-1:0] data_view_vec;
  logic [DW-1:0]       rd_word;
  logic                ctrl_wr;

  assign addr16  = 16'(addr);
  assign ctrl_wr = wr_stb && (addr16 == A_CTRL);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cfgsema_lane #(.DW(DW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_rd    (rd_stb && addr16 == reg_addr(l, SLOT_LOCK)),
      .data_rd    (rd_stb && addr16 == reg_addr(l, SLOT_DATA)),
      .data_wr    (wr_stb && addr16 == reg_addr(l, SLOT_DATA)),
      .addr_wr    (wr_stb && addr16 == reg_addr(l, SLOT_ADDR)),
      .ctrl_wr    (ctrl_wr),
      .ctrl_en_d  (wdata[en_bit(l)]),
      .ctrl_self_d(wdata[self_bit(l)]),
      .wdata      (wdata),
      .done       (lane_done[l]),
      .done_data  (lane_done_data[l*DW +: DW]),
      .lock_eff   (lock_eff_vec[l]),
      .lock_q     (lock_q_vec[l]),
      .en_q       (en_vec[l]),
      .self_q     (lane_self_en[l]),
      .addr_q     (lane_cfg_addr[l*DW +: DW]),
      .data_q     (lane_cfg_data[l*DW +: DW]),
      .data_view  (data_view_vec[l*DW +: DW]),
      .req_q      (lane_req[l]),
      .req_wr_q   (lane_req_wr[l]),
      .stall      (stall_vec[l]),
      .claim_ev   (claim_vec[l]),
      .release_ev (release_vec[l])
    );
  end

  cfgsema_rdmux #(.DW(DW), .LANES(LANES)) u_rdmux (
    .addr16    (addr16),
    .lock_eff  (lock_eff_vec),
    .en        (en_vec),
    .self_en   (lane_self_en),
    .addr_regs (lane_cfg_addr),
    .data_views(data_view_vec),
    .word      (rd_word)
  );

  assign busy = |stall_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= rd_word;
  end
endmodule

// File: rtl/cfgsema_chk.sv
module cfgsema_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_req,
  input logic [LANES-1:0] lane_done,
  input logic [LANES-1:0] lock_q,
  input logic [LANES-1:0] claim,
  input logic [LANES-1:0] release_ev,
  input logic [LANES-1:0] stall,
  input logic [LANES-1:0] en
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_claim_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      claim[l] |=> lock_q[l]);
    p_lock_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[l] && !release_ev[l] |=> lock_q[l]);
    p_done_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      release_ev[l] && !claim[l] |=> !lock_q[l]);
    p_no_lock_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en[l] && !lock_q[l] |=> !lock_q[l]);
    p_no_req_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en[l] |=> !lane_req[l]);
    p_stall_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall[l] |=> !lane_req[l]);
    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lane_req[l] && !lane_done[l] |=> !lane_req[l]);
  end
endmodule

bind cfgsema_top cfgsema_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_req  (lane_req),
  .lane_done (lane_done),
  .lock_q    (lock_q_vec),
  .claim     (claim_vec),
  .release_ev(release_vec),
  .stall     (stall_vec),
  .en        (en_vec)
);

// File: tb/sim_cfgsema_top.sv
`timescale 1ns/1ps
module sim_cfgsema_top;
  localparam int DW = 16;
  localparam int LANES = 2;
  localparam logic [7:0] CTRL = 8'h00, LOCK0 = 8'h10, ADR0 = 8'h12, DAT0 = 8'h14;
  localparam logic [7:0] LOCK1 = 8'h18;

  logic clk = 1'b0, rst_n = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic busy;
  logic [LANES-1:0] lane_req, lane_req_wr, lane_self_en, lane_done = '0;
  logic [LANES*DW-1:0] lane_cfg_addr, lane_cfg_data, lane_done_data = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cfgsema_top u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .lane_req(lane_req),
    .lane_req_wr(lane_req_wr), .lane_cfg_addr(lane_cfg_addr),
    .lane_cfg_data(lane_cfg_data), .lane_self_en(lane_self_en),
    .lane_done(lane_done), .lane_done_data(lane_done_data)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_stb = 1'b1; addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic complete(input int l, input logic [DW-1:0] d);
    @(negedge clk); lane_done[l] = 1'b1; lane_done_data[l*DW +: DW] = d;
    @(negedge clk); lane_done = '0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] d;
    rd(a, d);
    check(d == exp, req, 32'(d), 32'(exp));
  endtask

  task automatic t_reset;
    check(rdata == 0 && busy == 0 && lane_req == 0 && lane_self_en == 0, "R1",
          {rdata, 13'd0, busy, lane_req}, 32'h0);
    expect_rd(CTRL, 16'h0000, "R1");
  endtask

  task automatic t_disabled;
    expect_rd(LOCK0, 16'h0000, "R6");
    expect_rd(CTRL, 16'h0000, "R6");
    wr(DAT0, 16'h1234);
    check(lane_req == 0, "R6", 32'(lane_req), 32'h0);
    expect_rd(DAT0, 16'h0000, "R6");
  endtask

  task automatic t_ctrl_bits;
    wr(CTRL, 16'hFFFF);
    expect_rd(CTRL, 16'h000F, "R10");
    check(lane_self_en == 2'b11, "R10", 32'(lane_self_en), 32'h3);
    wr(CTRL, 16'h0005);
    check(lane_self_en == 2'b00, "R10", 32'(lane_self_en), 32'h0);
    wr(ADR0, 16'hBEEF);
    expect_rd(ADR0, 16'hBEEF, "R7");
    check(lane_cfg_addr[15:0] == 16'hBEEF, "R7", 32'(lane_cfg_addr[15:0]), 32'hBEEF);
  endtask

  task automatic t_status_then_claim;
    expect_rd(CTRL, 16'h0005, "R5");
    expect_rd(CTRL, 16'h0005, "R5");
    expect_rd(LOCK0, 16'h0000, "R5 R2");
    expect_rd(CTRL, 16'h0105, "R2");
  endtask

  task automatic t_hold;
    expect_rd(LOCK0, 16'h0001, "R3");
    expect_rd(LOCK0, 16'h0001, "R3");
    expect_rd(CTRL, 16'h0105, "R3");
  endtask

  task automatic t_release;
    complete(0, 16'h0);
    expect_rd(CTRL, 16'h0005, "R4");
    expect_rd(LOCK0, 16'h0000, "R4");
    expect_rd(CTRL, 16'h0105, "R4");
  endtask

  task automatic t_lanes;
    expect_rd(LOCK1, 16'h0000, "R11");
    expect_rd(CTRL, 16'h0305, "R11");
    complete(1, 16'h0);
    expect_rd(CTRL, 16'h0105, "R11");
  endtask

  task automatic t_write_req;
    wr(DAT0, 16'h5A5A);
    check(lane_req == 2'b01 && lane_req_wr == 2'b01, "R7", {lane_req, lane_req_wr}, 32'h5);
    check(lane_cfg_data[15:0] == 16'h5A5A && lane_cfg_addr[15:0] == 16'hBEEF, "R7",
          {lane_cfg_data[15:0], lane_cfg_addr[15:0]}, 32'h5A5ABEEF);
    @(negedge clk);
    check(lane_req == 2'b00, "R7", 32'(lane_req), 32'h0);
    complete(0, 16'h0);
  endtask

  task automatic t_read_req;
    expect_rd(DAT0, 16'h5A5A, "R7");
    check(lane_req == 2'b01 && lane_req_wr == 2'b00, "R7", {lane_req, lane_req_wr}, 32'h4);
    complete(0, 16'h0C0F);
    expect_rd(DAT0, 16'h0C0F, "R7");
    complete(0, 16'h0C0F);
  endtask

  task automatic t_busy;
    wr(DAT0, 16'h1111);
    @(negedge clk); wr_stb = 1'b1; addr = DAT0; wdata = 16'h2222;
    #1 check(busy == 1'b1, "R8", 32'(busy), 32'h1);
    @(negedge clk); wr_stb = 1'b0;
    check(lane_req == 2'b00, "R8", 32'(lane_req), 32'h0);
    check(lane_cfg_data[15:0] == 16'h1111, "R8", 32'(lane_cfg_data[15:0]), 32'h1111);
    complete(0, 16'h0);
    expect_rd(DAT0, 16'h1111, "R8");
    complete(0, 16'h1111);
  endtask

  task automatic t_simul;
    expect_rd(LOCK0, 16'h0000, "R9");
    @(negedge clk); rd_stb = 1'b1; addr = LOCK0; lane_done[0] = 1'b1;
    @(negedge clk); rd_stb = 1'b0; lane_done = '0;
    check(rdata == 16'h0000, "R9", 32'(rdata), 32'h0);
    expect_rd(CTRL, 16'h0105, "R9");
  endtask

  task automatic t_hold_rdata;
    wr(ADR0, 16'h0001);
    @(negedge clk);
    check(rdata == 16'h0105, "R12", 32'(rdata), 32'h0105);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_ctrl_bits();
    t_status_then_claim();
    t_hold();
    t_release();
    t_lanes();
    t_write_req();
    t_read_req();
    t_busy();
    t_simul();
    t_hold_rdata();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule